// File: doc/BRIEF.md
# Memory-Mapped Display Register Window Bridge

This bridge sits behind a 4 KiB memory-mapped window of a display controller. It turns each access on a simple valid/ready slave port into a short, ordered sequence of operations on two register back ends. The first back end is a file of 32 byte-wide legacy ports, reached through a remapped block in the window. The second is a bank of eleven 16-bit extended display registers, reached through an index register followed by a data register.

A wide access to the legacy block is split into byte operations. They are issued one per cycle, starting from the lowest address. Because of this, a single 16-bit write can load an index port and then the data port next to it. An access to the extended block becomes, for each 16-bit unit, an index write followed in the next cycle by a data read or data write. The slave port holds ready low while the operations run. It raises ready for one cycle with the assembled read data once the last operation has finished. An enable input switches the whole window off.

Top module: `mmio_window_bridge`

## Requirements
- R1: An access whose start offset lies in 0x400..0x41F is a legacy access. Each of its bytes becomes one byte-port operation with `bp_addr` = byte offset − 0x400. `bp_write` follows `s_write`, and write byte i is taken from `s_wdata[8i+7:8i]`.
- R2: An access whose start offset lies in 0x500..0x515 is an extended access. Each 16-bit unit at offset u gives one cycle with `ix_wr` high and `ix_val` = (u − 0x500) >> 1. In the next cycle either `dt_wr` is high (write) or `dt_rd` is high (read).
- R3: The access size is taken from `s_size`: 2'b00 means 1 byte, 2'b01 means 2 bytes, 2'b1x means 4 bytes. Legacy bytes are issued one per cycle in ascending address order, at most one back-end strobe per cycle. Read byte i is returned in `s_rdata[8i+7:8i]`, so a 4-byte access covers the lower half first and then the upper half.
- R4: A 4-byte extended access makes two units, at offset and offset+2, lower unit first. Unit k writes `s_wdata[16k+15:16k]` to `dt_wdata`, and its read value is returned in `s_rdata[16k+15:16k]`.
- R5: A 1-byte extended read performs the index write and data read for the register that contains the byte. It returns the low register byte when offset bit 0 is 0 and the high byte when it is 1, in `s_rdata[7:0]` with all other bits zero. A 1-byte extended write issues no operation.
- R6: A byte or unit whose own offset falls past the end of its region (beyond 0x41F or beyond 0x515) issues no strobe and reads as zero. It still occupies its cycle slot, one slot per byte and two per unit.
- R7: An access accepted while `win_en` is low issues no operation and reads as zero.
- R8: An access whose start offset is outside both regions issues no operation and reads as zero.
- R9: With N slots (legacy: one per byte; extended: two per unit; zero for R5 writes, R7 and R8), `s_ready` rises after exactly N+1 rising edges counted from the edge that accepts `s_valid` in the idle state. It stays high for one cycle, and `s_rdata` is zero whenever `s_ready` is low.
- R10: While `rst_n` is low, `s_ready` and all back-end strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_en | input | 1 | Window enable, sampled when an access is accepted |
| s_valid | input | 1 | Access request; held until the `s_ready` cycle |
| s_ready | output | 1 | One-cycle completion pulse |
| s_addr | input | 12 | Byte offset in the window |
| s_size | input | 2 | Access size code (see R3) |
| s_write | input | 1 | 1 = write, 0 = read |
| s_wdata | input | 32 | Write data, little-endian |
| s_rdata | output | 32 | Read data, valid with `s_ready` |
| bp_valid | output | 1 | Byte-port operation strobe |
| bp_write | output | 1 | Byte-port direction |
| bp_addr | output | 5 | Byte-port number |
| bp_wdata | output | 8 | Byte-port write data |
| bp_rdata | input | 8 | Byte-port read data, combinational on `bp_addr` |
| ix_wr | output | 1 | Extended index write strobe |
| ix_val | output | 4 | Extended index value |
| dt_rd | output | 1 | Extended data read strobe |
| dt_wr | output | 1 | Extended data write strobe |
| dt_wdata | output | 16 | Extended data write value |
| dt_rdata | input | 16 | Extended data read value for the current index |

## Verification
The hardest cases to reach are the partial-region accesses: a wide access that starts inside a region and runs past its end. Here some slots strobe and others stay silent, yet every slot still costs a cycle. The stimulus places 2-byte and 4-byte accesses on the last legacy port and on the last extended register. The reference model predicts, slot by slot, whether a strobe appears and which byte lanes of the read data must stay zero. Index-before-data ordering is exposed by the stand-in extended bank, which answers a data read from whichever index was written last.

// File: rtl/mwb_pkg.sv
package mwb_pkg;

  localparam int unsigned BUS_BYTES = 4;
  localparam int unsigned BUS_W     = 8 * BUS_BYTES;

  typedef enum logic [1:0] {RG_NONE, RG_LEG, RG_EXT} region_e;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_RESP} state_e;

  // True when a lies in [base, base+len).
  function automatic logic in_span(input logic [31:0] a,
                                   input logic [31:0] base,
                                   input logic [31:0] len);
    return (a >= base) && (a < base + len);
  endfunction

  // Size code to byte count: 00 -> 1, 01 -> 2, 1x -> 4.
  function automatic logic [2:0] bytes_of(input logic [1:0] sz);
    return sz[1] ? 3'd4 : (sz[0] ? 3'd2 : 3'd1);
  endfunction

endpackage

// File: rtl/mwb_decode.sv
module mwb_decode
  import mwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEG_BASE  = 'h400,
  parameter int unsigned LEG_PORTS = 32,
  parameter int unsigned EXT_BASE  = 'h500,
  parameter int unsigned EXT_REGS  = 11,
  parameter int unsigned SLOT_W    = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  input  logic              en,
  output region_e           region,
  output logic [SLOT_W-1:0] nslots
);

  always_comb begin
    region = RG_NONE;
    nslots = '0;
    if (en) begin
      if (in_span(32'(addr), LEG_BASE, LEG_PORTS)) begin
        region = RG_LEG;
        nslots = SLOT_W'(bytes_of(size));
      end else if (in_span(32'(addr), EXT_BASE, 2 * EXT_REGS)) begin
        region = RG_EXT;
        if (!(size == 2'b00 && write))
          nslots = size[1] ? SLOT_W'(4) : SLOT_W'(2);
      end
    end
  end

endmodule

// File: rtl/mwb_slot.sv
module mwb_slot
  import mwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEG_BASE  = 'h400,
  parameter int unsigned LEG_PORTS = 32,
  parameter int unsigned EXT_BASE  = 'h500,
  parameter int unsigned EXT_REGS  = 11,
  parameter int unsigned SLOT_W    = 3,
  parameter int unsigned PORT_W    = 5,
  parameter int unsigned IDX_W     = 4
) (
  input  logic              active,
  input  region_e           region,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [BUS_W-1:0]  wdata,
  input  logic [SLOT_W-1:0] slot,
  output logic              bp_valid,
  output logic              bp_write,
  output logic [PORT_W-1:0] bp_addr,
  output logic [7:0]        bp_wdata,
  output logic              ix_wr,
  output logic [IDX_W-1:0]  ix_val,
  output logic              dt_rd,
  output logic              dt_wr,
  output logic [15:0]       dt_wdata
);

  logic [ADDR_W-1:0] byte_off;
  logic [ADDR_W-1:0] unit_off;
  logic [1:0]        lane;

  assign lane     = slot[1:0];
  assign byte_off = addr + ADDR_W'(slot);
  assign unit_off = addr + ADDR_W'({slot[SLOT_W-1:1], 1'b0});

  always_comb begin
    bp_valid = 1'b0;
    bp_write = 1'b0;
    bp_addr  = '0;
    bp_wdata = '0;
    ix_wr    = 1'b0;
    ix_val   = '0;
    dt_rd    = 1'b0;
    dt_wr    = 1'b0;
    dt_wdata = '0;
    if (active) begin
      case (region)
        RG_LEG: if (in_span(32'(byte_off), LEG_BASE, LEG_PORTS)) begin
          bp_valid = 1'b1;
          bp_write = write;
          bp_addr  = PORT_W'(byte_off - ADDR_W'(LEG_BASE));
          bp_wdata = wdata[{lane, 3'b000} +: 8];
        end
        RG_EXT: if (in_span(32'(unit_off), EXT_BASE, 2 * EXT_REGS)) begin
          if (!slot[0]) begin
            ix_wr  = 1'b1;
            ix_val = IDX_W'((unit_off - ADDR_W'(EXT_BASE)) >> 1);
          end else begin
            dt_wr    = write;
            dt_rd    = !write;
            dt_wdata = wdata[{lane[1], 4'b0000} +: 16];
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/mmio_window_bridge.sv
module mmio_window_bridge
  import mwb_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned LEG_BASE  = 'h400,
  parameter int unsigned LEG_PORTS = 32,
  parameter int unsigned EXT_BASE  = 'h500,
  parameter int unsigned EXT_REGS  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win_en,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic [1:0]        s_size,
  input  logic              s_write,
  input  logic [31:0]       s_wdata,
  output logic [31:0]       s_rdata,
  output logic              bp_valid,
  output logic              bp_write,
  output logic [4:0]        bp_addr,
  output logic [7:0]        bp_wdata,
  input  logic [7:0]        bp_rdata,
  output logic              ix_wr,
  output logic [3:0]        ix_val,
  output logic              dt_rd,
  output logic              dt_wr,
  output logic [15:0]       dt_wdata,
  input  logic [15:0]       dt_rdata
);

  localparam int unsigned SLOT_W = $clog2(BUS_BYTES + 1);
  localparam int unsigned PORT_W = $clog2(LEG_PORTS);
  localparam int unsigned IDX_W  = $clog2(EXT_REGS);

  state_e            state_q;
  region_e           region_q, dec_region;
  logic [SLOT_W-1:0] slot_q, nslots_q, dec_nslots;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        size_q;
  logic              write_q;
  logic [BUS_W-1:0]  wdata_q;
  logic [BUS_W-1:0]  acc_q;

  // Named internal events.
  logic accept, running, last_slot, any_op;

  assign accept    = (state_q == ST_IDLE) && s_valid;
  assign running   = (state_q == ST_RUN);
  assign last_slot = running && (slot_q == nslots_q - SLOT_W'(1));

  mwb_decode #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_PORTS(LEG_PORTS),
    .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .SLOT_W(SLOT_W)
  ) u_decode (
    .addr(s_addr), .size(s_size), .write(s_write), .en(win_en),
    .region(dec_region), .nslots(dec_nslots)
  );

  mwb_slot #(
    .ADDR_W(ADDR_W), .LEG_BASE(LEG_BASE), .LEG_PORTS(LEG_PORTS),
    .EXT_BASE(EXT_BASE), .EXT_REGS(EXT_REGS), .SLOT_W(SLOT_W),
    .PORT_W(PORT_W), .IDX_W(IDX_W)
  ) u_slot (
    .active(running), .region(region_q), .addr(addr_q), .write(write_q),
    .wdata(wdata_q), .slot(slot_q),
    .bp_valid(bp_valid), .bp_write(bp_write), .bp_addr(bp_addr),
    .bp_wdata(bp_wdata), .ix_wr(ix_wr), .ix_val(ix_val),
    .dt_rd(dt_rd), .dt_wr(dt_wr), .dt_wdata(dt_wdata)
  );

  assign any_op = bp_valid || ix_wr || dt_rd || dt_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      region_q <= RG_NONE;
      slot_q   <= '0;
      nslots_q <= '0;
      addr_q   <= '0;
      size_q   <= '0;
      write_q  <= 1'b0;
      wdata_q  <= '0;
      acc_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          region_q <= dec_region;
          nslots_q <= dec_nslots;
          slot_q   <= '0;
          addr_q   <= s_addr;
          size_q   <= s_size;
          write_q  <= s_write;
          wdata_q  <= s_wdata;
          acc_q    <= '0;
          state_q  <= (dec_nslots == '0) ? ST_RESP : ST_RUN;
        end
        ST_RUN: begin
          if (bp_valid && !bp_write)
            acc_q[{slot_q[1:0], 3'b000} +: 8] <= bp_rdata;
          if (dt_rd)
            acc_q[{slot_q[1], 4'b0000} +: 16] <= dt_rdata;
          slot_q <= slot_q + SLOT_W'(1);
          if (last_slot) state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [BUS_W-1:0] final_data;
  always_comb begin
    final_data = acc_q;
    if (region_q == RG_EXT && size_q == 2'b00)
      final_data = {24'b0, addr_q[0] ? acc_q[15:8] : acc_q[7:0]};
  end

  assign s_ready = (state_q == ST_RESP);
  assign s_rdata = s_ready ? final_data : '0;

  // Guards.
  AST_ONE_OP_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({bp_valid, ix_wr, dt_rd, dt_wr}));                              // R3
  AST_INDEX_BEFORE_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_rd || dt_wr) |-> $past(ix_wr));                                      // R2
  AST_LEG_ASCENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (bp_valid && $past(bp_valid)) |-> (bp_addr == PORT_W'($past(bp_addr) + 1'b1))); // R3
  AST_EXT_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ix_wr |-> (32'(ix_val) < EXT_REGS));                                     // R6
  AST_OFF_IS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !win_en) |=> (s_ready && !any_op));                           // R7
  AST_READY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready);                                                   // R9
  AST_NO_OP_IN_RESP: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |-> !any_op);                                                    // R9

endmodule

// File: tb/mmio_window_bridge_bench.sv
module mmio_window_bridge_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_en = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_addr = '0;
  logic [1:0]  s_size = '0;
  logic        s_write = 1'b0;
  logic [31:0] s_wdata = '0;
  logic [31:0] s_rdata;
  logic        bp_valid, bp_write;
  logic [4:0]  bp_addr;
  logic [7:0]  bp_wdata, bp_rdata;
  logic        ix_wr, dt_rd, dt_wr;
  logic [3:0]  ix_val;
  logic [15:0] dt_wdata, dt_rdata;

  always #10 clk = ~clk;

  mmio_window_bridge u_mmio_window_bridge (
    .clk, .rst_n, .win_en, .s_valid, .s_ready, .s_addr, .s_size, .s_write,
    .s_wdata, .s_rdata, .bp_valid, .bp_write, .bp_addr, .bp_wdata, .bp_rdata,
    .ix_wr, .ix_val, .dt_rd, .dt_wr, .dt_wdata, .dt_rdata
  );

  // Stand-in back ends.
  logic [7:0]  leg_mem [32];
  logic [15:0] ext_mem [11];
  logic [3:0]  ext_idx;

  function automatic logic [7:0] leg_init(input int i);
    return 8'(i * 13 + 5);
  endfunction
  function automatic logic [15:0] ext_init(input int i);
    return 16'(i * 257 + 'h1000);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 32; i++) leg_mem[i] <= leg_init(i);
      for (int i = 0; i < 11; i++) ext_mem[i] <= ext_init(i);
      ext_idx <= '0;
    end else begin
      if (bp_valid && bp_write) leg_mem[bp_addr] <= bp_wdata;
      if (ix_wr) ext_idx <= ix_val;
      if (dt_wr && ext_idx < 4'd11) ext_mem[ext_idx] <= dt_wdata;
    end
  end
  assign bp_rdata = leg_mem[bp_addr];
  assign dt_rdata = (ext_idx < 4'd11) ? ext_mem[ext_idx] : 16'h0;

  // Reference model state.
  int sh_leg [32];
  int sh_ext [11];
  int checks = 0;
  int failures = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int observed();
    if (bp_valid) return ((bp_write ? 1 : 2) << 24) | (int'(bp_addr) << 16) | (bp_write ? int'(bp_wdata) : 0);
    if (ix_wr)    return (3 << 24) | (int'(ix_val) << 16);
    if (dt_wr)    return (4 << 24) | int'(dt_wdata);
    if (dt_rd)    return (5 << 24);
    return 0;
  endfunction

  task automatic access(input bit en, input int addr, input int sz, input bit wr,
                        input logic [31:0] wd, input string tag);
    int nb;
    int ek [8];
    int n;
    int a;
    int units;
    logic [31:0] exp_rd;
    nb = (sz >= 2) ? 4 : (sz == 1 ? 2 : 1);
    n = 0;
    exp_rd = '0;
    if (en && addr >= 'h400 && addr < 'h420) begin
      for (int i = 0; i < nb; i++) begin
        a = addr + i;
        if (a < 'h420) begin
          if (wr) begin
            ek[n] = (1 << 24) | ((a - 'h400) << 16) | int'((wd >> (8 * i)) & 32'hFF);
            sh_leg[a - 'h400] = int'((wd >> (8 * i)) & 32'hFF);
          end else begin
            ek[n] = (2 << 24) | ((a - 'h400) << 16);
            exp_rd = exp_rd | (32'(sh_leg[a - 'h400]) << (8 * i));
          end
        end else ek[n] = 0;
        n++;
      end
    end else if (en && addr >= 'h500 && addr < 'h516 && !(nb == 1 && wr)) begin
      units = (nb == 4) ? 2 : 1;
      for (int u = 0; u < units; u++) begin
        a = addr + 2 * u;
        if (a < 'h516) begin
          ek[n++] = (3 << 24) | (((a - 'h500) / 2) << 16);
          if (wr) begin
            ek[n++] = (4 << 24) | int'((wd >> (16 * u)) & 32'hFFFF);
            sh_ext[(a - 'h500) / 2] = int'((wd >> (16 * u)) & 32'hFFFF);
          end else begin
            ek[n++] = (5 << 24);
            exp_rd = exp_rd | (32'(sh_ext[(a - 'h500) / 2]) << (16 * u));
          end
        end else begin
          ek[n++] = 0;
          ek[n++] = 0;
        end
      end
      if (nb == 1) exp_rd = (addr % 2 == 1) ? ((exp_rd >> 8) & 32'hFF) : (exp_rd & 32'hFF);
    end
    win_en  = en;
    s_addr  = 12'(addr);
    s_size  = 2'(sz);
    s_write = wr;
    s_wdata = wd;
    s_valid = 1'b1;
    @(posedge clk);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(observed() == ek[k], tag, $sformatf("slot %0d op", k), observed(), ek[k]);
      chk(s_ready == 1'b0, "R9", "ready low while running", s_ready, 0);
      @(posedge clk);
    end
    @(negedge clk);
    chk(s_ready == 1'b1, "R9", $sformatf("ready after %0d slots", n), s_ready, 1);
    chk(s_rdata == exp_rd, tag, "read data", s_rdata, exp_rd);
    chk(observed() == 0, "R9", "no op in response cycle", observed(), 0);
    @(posedge clk);
    @(negedge clk);
    s_valid = 1'b0;
    chk(s_ready == 1'b0 && s_rdata == 0, "R9", "single-cycle ready, zero data", {s_ready, s_rdata}, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 32; i++) sh_leg[i] = int'(leg_init(i));
    for (int i = 0; i < 11; i++) sh_ext[i] = int'(ext_init(i));
    repeat (3) begin
      @(negedge clk);
      chk(s_ready == 0 && observed() == 0, "R10", "quiet in reset", {s_ready, observed()}, 0);
    end
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: single bytes
    access(1, 'h405, 0, 1, 32'hA5, "R1");
    access(1, 'h405, 0, 0, 0, "R1");
    access(1, 'h400, 0, 0, 0, "R1");
    // R3: word pair, dword
    access(1, 'h414, 1, 1, 32'hBEEF, "R3");
    access(1, 'h414, 1, 0, 0, "R3");
    access(1, 'h408, 2, 1, 32'h44332211, "R3");
    access(1, 'h408, 2, 0, 0, "R3");
    access(1, 'h40A, 1, 0, 0, "R3");
    // R6: legacy tail past end
    access(1, 'h41F, 1, 1, 32'h7E3C, "R6");
    access(1, 'h41E, 2, 0, 0, "R6");
    // R2 / R4: extended
    access(1, 'h504, 1, 1, 32'h1234, "R2");
    access(1, 'h504, 1, 0, 0, "R2");
    access(1, 'h503, 1, 0, 0, "R2");
    access(1, 'h508, 3, 1, 32'hCAFE0BAD, "R4");
    access(1, 'h508, 2, 0, 0, "R4");
    // R5: byte access to extended
    access(1, 'h509, 0, 0, 0, "R5");
    access(1, 'h508, 0, 0, 0, "R5");
    access(1, 'h504, 0, 1, 32'h77, "R5");
    access(1, 'h504, 1, 0, 0, "R5");
    // R6: extended tail past end
    access(1, 'h514, 2, 1, 32'h99998888, "R6");
    access(1, 'h514, 2, 0, 0, "R6");
    // R7: disabled window
    access(0, 'h405, 0, 1, 32'h11, "R7");
    access(0, 'h504, 1, 0, 0, "R7");
    access(1, 'h405, 0, 0, 0, "R7");
    // R8: outside both regions
    access(1, 'h000, 2, 1, 32'hDEADBEEF, "R8");
    access(1, 'h420, 1, 0, 0, "R8");
    access(1, 'h516, 1, 0, 0, "R8");
    access(1, 'hFFF, 0, 0, 0, "R8");
    access(1, 'h3FF, 1, 0, 0, "R8");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule